// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node of a directory-based coherence scheme for up to eight processors. For every memory block it owns, it keeps a coherence state and a bit vector of the processors that hold a copy. It also keeps a small backing store with one data word per block. Request messages arrive one at a time on a valid/ready port. There are three kinds: a read miss, a write miss and a data writeback. Each carries the requesting processor and the block index. The controller updates its directory and sends point-to-point messages on a single outgoing channel, at most one message per cycle. The message kinds are a data reply, an invalidate, a fetch and a fetch-invalidate.

A block is Uncached, Shared or Exclusive. In the Shared state memory holds the current value and one or more processors hold a copy. In the Exclusive state a single owner holds the only current copy and memory is stale. A write to a shared block sends invalidates to the other sharers, one per cycle in ascending processor order, and then sends the data reply. A miss to an exclusive block sends a fetch to the owner. The controller then lowers its ready signal until the owner's data comes back on the owner-data port, and forwards that data to the requester. The network, the cache-side controllers and races between crossing messages are handled elsewhere.

Top module: `dir_home`

## Requirements
- R1: A read miss (req_kind 0) to an Uncached block produces, in the cycle after acceptance, a data reply (msg_kind 0) to the requester carrying the stored word. The block becomes Shared with the requester as its only sharer.
- R2: A write miss (req_kind 1) to an Uncached block produces a data reply to the requester in the next cycle. The block becomes Exclusive, owned by the requester.
- R3: A read miss to a Shared block produces a data reply from memory in the next cycle and adds the requester to the sharers already present.
- R4: A write miss to a Shared block sends one invalidate (msg_kind 1) per cycle to each sharer other than the requester, in ascending processor ID, starting in the cycle after acceptance. A data reply from memory follows in the next cycle. The block becomes Exclusive, owned by the requester.
- R5: A read miss to an Exclusive block sends a fetch (msg_kind 2) to the owner in the next cycle. In the cycle after the owner's data arrives, that data is stored in memory and sent to the requester. The block becomes Shared by the old owner and the requester.
- R6: A write miss to an Exclusive block sends a fetch-invalidate (msg_kind 3) to the owner. The returned data is forwarded to the requester in the next cycle. The block stays Exclusive with the requester as its only owner.
- R7: A data writeback (req_kind 2) from the owner of an Exclusive block stores its data and makes the block Uncached, and it sends no message. A writeback from any other processor, or to a block that is not Exclusive, changes nothing.
- R8: req_ready is low from acceptance until the last invalidate of a sequence has been sent, and while the controller waits for owner data. A request presented in that time is not taken and has no effect.
- R9: Owner data presented while no fetch is outstanding is ignored.
- R10: After reset, req_ready is high, no message is valid, every block is Uncached and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_src | input | $clog2(NPROC) | Requesting processor |
| req_addr | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Writeback data |
| own_valid | input | 1 | Owner data returning after a fetch |
| own_data | input | DW | Owner's block data |
| msg_valid | output | 1 | Outgoing message valid this cycle |
| msg_kind | output | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-invalidate |
| msg_dst | output | $clog2(NPROC) | Destination processor |
| msg_addr | output | $clog2(NBLK) | Block index of the message |
| msg_data | output | DW | Data for a reply |

## Verification
Every message is registered. The first message of a request therefore appears in the cycle after the clock edge that accepted it. Each further invalidate, and the final reply, appear one cycle after the previous message. A forwarded reply appears one cycle after owner data is presented. The bench model works at the same edges: on acceptance it queues the whole expected message sequence, it pops one entry per edge, and at the falling edge it compares both the message port and req_ready against the popped entry, or against an idle channel. Requests presented while the controller is busy, stray owner data and wrong writebacks are judged by the replies and invalidates that later traffic to the same block produces.

// File: rtl/dir_home.sv
module dir_home #(
  parameter int NPROC = 8,
  parameter int NBLK  = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_kind,
  input  logic [$clog2(NPROC)-1:0] req_src,
  input  logic [$clog2(NBLK)-1:0]  req_addr,
  input  logic [DW-1:0]            req_data,
  input  logic                     own_valid,
  input  logic [DW-1:0]            own_data,
  output logic                     msg_valid,
  output logic [1:0]               msg_kind,
  output logic [$clog2(NPROC)-1:0] msg_dst,
  output logic [$clog2(NBLK)-1:0]  msg_addr,
  output logic [DW-1:0]            msg_data
);
  localparam int PW = $clog2(NPROC);
  localparam int AW = $clog2(NBLK);

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
  localparam logic [1:0] M_REPLY = 2'd0, M_INV = 2'd1, M_FETCH = 2'd2, M_FINV = 2'd3;

  typedef enum logic [1:0] {B_UNC, B_SHR, B_EXC} blk_t;
  typedef enum logic [1:0] {C_IDLE, C_INV, C_WAIT} ctl_t;

  blk_t             bst [NBLK];
  logic [NPROC-1:0] bsh [NBLK];
  logic [DW-1:0]    mem [NBLK];

  ctl_t             ctl;
  logic [PW-1:0]    p_src;
  logic [AW-1:0]    p_addr;
  logic             p_wr;
  logic [NPROC-1:0] p_mask;

  function automatic logic [PW-1:0] first_one(input logic [NPROC-1:0] v);
    first_one = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (v[i]) first_one = PW'(i);
  endfunction

  blk_t             cur_st;
  logic [NPROC-1:0] cur_sh, req_bit, inv_mask;
  logic [PW-1:0]    inv_first, pm_first, owner;
  logic             accept;

  assign req_ready = (ctl == C_IDLE);
  assign accept    = req_valid && req_ready;
  assign cur_st    = bst[req_addr];
  assign cur_sh    = bsh[req_addr];
  assign req_bit   = NPROC'(1) << req_src;
  assign inv_mask  = cur_sh & ~req_bit;
  assign inv_first = first_one(inv_mask);
  assign pm_first  = first_one(p_mask);
  assign owner     = first_one(cur_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= C_IDLE;
      p_src     <= '0;
      p_addr    <= '0;
      p_wr      <= 1'b0;
      p_mask    <= '0;
      msg_valid <= 1'b0;
      msg_kind  <= M_REPLY;
      msg_dst   <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
      for (int b = 0; b < NBLK; b++) begin
        bst[b] <= B_UNC;
        bsh[b] <= '0;
        mem[b] <= '0;
      end
    end else begin
      msg_valid <= 1'b0;
      case (ctl)
        C_IDLE: if (accept) begin
          p_src  <= req_src;
          p_addr <= req_addr;
          msg_addr <= req_addr;
          msg_data <= mem[req_addr];
          case (req_kind)
            K_RD: begin
              msg_valid <= 1'b1;
              if (cur_st == B_EXC) begin
                msg_kind <= M_FETCH;
                msg_dst  <= owner;
                p_wr     <= 1'b0;
                ctl      <= C_WAIT;
              end else begin
                msg_kind      <= M_REPLY;
                msg_dst       <= req_src;
                bst[req_addr] <= B_SHR;
                bsh[req_addr] <= cur_sh | req_bit;
              end
            end
            K_WR: begin
              msg_valid <= 1'b1;
              if (cur_st == B_EXC) begin
                msg_kind <= M_FINV;
                msg_dst  <= owner;
                p_wr     <= 1'b1;
                ctl      <= C_WAIT;
              end else begin
                bst[req_addr] <= B_EXC;
                bsh[req_addr] <= req_bit;
                if (cur_st == B_SHR && inv_mask != '0) begin
                  msg_kind <= M_INV;
                  msg_dst  <= inv_first;
                  p_mask   <= inv_mask & ~(NPROC'(1) << inv_first);
                  ctl      <= C_INV;
                end else begin
                  msg_kind <= M_REPLY;
                  msg_dst  <= req_src;
                end
              end
            end
            K_WB: if (cur_st == B_EXC && cur_sh == req_bit) begin
              mem[req_addr] <= req_data;
              bst[req_addr] <= B_UNC;
              bsh[req_addr] <= '0;
            end
            default: ;
          endcase
        end
        C_INV: begin
          msg_valid <= 1'b1;
          if (p_mask != '0) begin
            msg_kind <= M_INV;
            msg_dst  <= pm_first;
            p_mask   <= p_mask & ~(NPROC'(1) << pm_first);
          end else begin
            msg_kind <= M_REPLY;
            msg_dst  <= p_src;
            msg_data <= mem[p_addr];
            ctl      <= C_IDLE;
          end
        end
        C_WAIT: if (own_valid) begin
          mem[p_addr] <= own_data;
          msg_valid   <= 1'b1;
          msg_kind    <= M_REPLY;
          msg_dst     <= p_src;
          msg_data    <= own_data;
          bst[p_addr] <= p_wr ? B_EXC : B_SHR;
          bsh[p_addr] <= p_wr ? (NPROC'(1) << p_src) : (bsh[p_addr] | (NPROC'(1) << p_src));
          ctl         <= C_IDLE;
        end
        default: ctl <= C_IDLE;
      endcase
    end
  end

  p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == C_WAIT && !own_valid) |=> !msg_valid);
  p_wait_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == C_WAIT && own_valid) |=> (msg_valid && msg_kind == M_REPLY && msg_data == $past(own_data)));
  p_inv_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == M_INV) |-> (msg_dst != p_src));
  p_inv_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == M_INV) |=> (!(msg_valid && msg_kind == M_INV) || msg_dst > $past(msg_dst)));
  p_idle_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == C_INV) |=> (msg_valid && (msg_kind == M_INV || msg_kind == M_REPLY)));

  for (genvar b = 0; b < NBLK; b++) begin : g_chk
    p_excl_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bst[b] == B_EXC) |-> ($countones(bsh[b]) == 1));
    p_unc_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bst[b] == B_UNC) |-> (bsh[b] == '0));
    p_shr_some_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bst[b] == B_SHR) |-> (bsh[b] != '0));
  end
endmodule

// File: tb/dir_home_tb.sv
module dir_home_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, own_valid = 0;
  logic [1:0] req_kind = 0;
  logic [2:0] req_src = 0;
  logic [3:0] req_addr = 0;
  logic [31:0] req_data = 0, own_data = 0;
  logic req_ready, msg_valid;
  logic [1:0] msg_kind;
  logic [2:0] msg_dst;
  logic [3:0] msg_addr;
  logic [31:0] msg_data;

  always #10 clk = ~clk;

  dir_home u_dut (.clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_src, .req_addr,
                  .req_data, .own_valid, .own_data, .msg_valid, .msg_kind, .msg_dst,
                  .msg_addr, .msg_data);

  typedef struct { int kind; int dst; int addr; logic [31:0] data; string tag; } em_t;
  em_t q[$];
  em_t e;
  int ms [16];
  logic [7:0] msh [16];
  logic [31:0] mm [16];
  bit m_wait, m_ready, exp_v, wwr;
  int wsrc, wa;
  string wtag, ctx = "R10";
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  function automatic int low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic push(input int k, input int d, input int a, input logic [31:0] x, input string t);
    em_t n;
    n.kind = k; n.dst = d; n.addr = a; n.data = x; n.tag = t;
    q.push_back(n);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_wait = 0; m_ready = 1; exp_v = 0;
      for (int b = 0; b < 16; b++) begin ms[b] = 0; msh[b] = 0; mm[b] = 0; end
    end else begin
      if (m_wait) begin
        if (own_valid) begin
          mm[wa] = own_data;
          push(0, wsrc, wa, own_data, wtag);
          if (wwr) begin ms[wa] = 2; msh[wa] = 8'(1 << wsrc); end
          else begin ms[wa] = 1; msh[wa] = msh[wa] | 8'(1 << wsrc); end
          m_wait = 0;
        end
      end else if (q.size() == 0 && req_valid) begin
        int a, s;
        logic [7:0] bt;
        a = req_addr; s = req_src; bt = 8'(1 << s);
        if (req_kind == 0) begin
          if (ms[a] == 2) begin
            push(2, low(msh[a]), a, mm[a], "R5");
            m_wait = 1; wsrc = s; wa = a; wwr = 0; wtag = "R5";
          end else begin
            push(0, s, a, mm[a], ms[a] == 0 ? "R1" : "R3");
            ms[a] = 1; msh[a] = msh[a] | bt;
          end
        end else if (req_kind == 1) begin
          if (ms[a] == 2) begin
            push(3, low(msh[a]), a, mm[a], "R6");
            m_wait = 1; wsrc = s; wa = a; wwr = 1; wtag = "R6";
          end else begin
            if (ms[a] == 1)
              for (int i = 0; i < 8; i++) if (msh[a][i] && i != s) push(1, i, a, mm[a], "R4");
            push(0, s, a, mm[a], ms[a] == 0 ? "R2" : "R4");
            ms[a] = 2; msh[a] = bt;
          end
        end else if (req_kind == 2) begin
          if (ms[a] == 2 && msh[a] == bt) begin mm[a] = req_data; ms[a] = 0; msh[a] = 0; end
        end
      end
      if (q.size() != 0) begin e = q.pop_front(); exp_v = 1; end
      else exp_v = 0;
      m_ready = (q.size() == 0) && !m_wait;
    end
  end

  task automatic ck(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] act, exv;
      act = {23'd0, msg_valid, msg_kind, msg_dst, msg_addr, msg_data};
      if (exp_v) begin
        exv = {23'd0, 1'b1, 2'(e.kind), 3'(e.dst), 4'(e.addr), e.data};
        ck(act == exv, e.tag, act, exv);
      end else begin
        ck(!msg_valid, ctx, act, 64'd0);
      end
      ck(req_ready == m_ready, "R8", 64'(req_ready), 64'(m_ready));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input int k, input int s, input int a, input logic [31:0] d);
    while (!m_ready) @(negedge clk);
    req_valid = 1; req_kind = 2'(k); req_src = 3'(s); req_addr = 4'(a); req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic poke(input int k, input int s, input int a, input logic [31:0] d);
    req_valid = 1; req_kind = 2'(k); req_src = 3'(s); req_addr = 4'(a); req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic owner(input logic [31:0] d);
    own_valid = 1; own_data = d;
    @(negedge clk);
    own_valid = 0;
  endtask

  task automatic settle();
    while (!m_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    ctx = "R1"; send(0, 1, 3, 0); settle();
    ctx = "R3"; send(0, 4, 3, 0); send(0, 6, 3, 0); settle();
    ctx = "R4"; send(1, 4, 3, 0);
    ctx = "R8"; poke(0, 5, 3, 0); settle();
    ctx = "R5"; send(0, 2, 3, 0);
    ctx = "R8"; @(negedge clk); poke(1, 6, 7, 0); @(negedge clk);
    ctx = "R5"; owner(32'hA5A5_0001); settle();
    ctx = "R4"; send(1, 7, 3, 0); settle();
    ctx = "R6"; send(1, 0, 3, 0); @(negedge clk); owner(32'h0000_1234); settle();
    ctx = "R9"; owner(32'hDEAD_BEEF); settle();
    ctx = "R7"; send(2, 5, 3, 32'h0BAD_0BAD); send(2, 0, 3, 32'h5555_5555); settle();
    send(0, 3, 3, 0); settle();
    ctx = "R2"; send(1, 2, 9, 0); settle(); send(0, 5, 9, 0); owner(32'h77); settle();
    ctx = "R4"; send(1, 3, 3, 0); settle();
    ctx = "R7"; send(2, 1, 12, 32'hFFFF_0000); send(0, 1, 12, 0); settle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule